// File: doc/BRIEF.md
# Exception Entry Sequencer

This unit performs the multi-cycle work a processor core needs to enter an exception handler. When the core raises a request, the unit latches the cause (break, non-maskable interrupt, bus fault or external interrupt) and the architectural state it needs. That state is the current PC, the pending delay-slot count, three candidate vector numbers, the status word, the stack pointer, the kernel stack pointer and the vector-table base. From these it works out the vector number, the saved return address and the register that receives it, the new status word and any stack-pointer swap.

It then reads the handler address from the vector table through a simple request/acknowledge read port. When the word returns, it presents every register update at once, with a one-cycle write enable for each, and it presents the new PC. A version input selects a legacy rule set when its value is below 32. In that mode the return-register choice, the status-word update and the bus-fault handling are different.

The core holds off further requests while `busy` is high. It applies the write enables in the cycle where `done` is high.

Top module: `exc_entry_seq`

## Requirements
- R1: A break request (cause code 0) in normal mode selects the trap vector, and writes the PC less the delay-slot count into the exception return register (`erp_we`).
- R2: An NMI request (cause code 1) in normal mode selects vector 0 and writes the return address into the NMI return register (`nrp_we`). Status bit 9 is cleared before the status shift.
- R3: In normal mode, a bus fault (cause code 2) selects the fault vector and an interrupt (cause code 3) selects the interrupt vector. Both write the exception return register. At most one return register is written per entry.
- R4: In normal mode the exception status word holds the low 8 bits of the chosen vector in bits 15:8, and every other bit is zero.
- R5: In normal mode a nonzero delay-slot count is subtracted from the saved return address, and `dslot_clr` pulses at completion. A zero count leaves the address unchanged and `dslot_clr` low.
- R6: In both modes, when user-mode bit 8 of the incoming status word is set, the old SP is written to the user stack register and SP is loaded from the kernel SP. When that bit is clear, neither of those writes happens.
- R7: In normal mode the new status word keeps bits 31:30, carries old bits 19:0 into bits 29:10 and clears bits 9:0. This also clears user-mode bit 8.
- R8: The handler address is read as one word from EBP + 4 × vector, and the returned word becomes the new PC.
- R9: In legacy mode (version below 32), break and NMI save the unrewound PC into the break return register (`brp_we`), and an interrupt saves it into the exception return register. NMI clears status bit 7, and status bit 6 is set with no shift applied. No status word is written, no delay-slot rewind happens, and `irq_lock` pulses at completion.
- R10: A legacy-mode bus fault raises `bus_err` for exactly one cycle one clock after acceptance. It issues no read and no register write, and the unit is then idle.
- R11: `busy` is high from the clock after acceptance until the clock after completion. Requests that arrive while busy are ignored. The read address stays stable while a read waits for its acknowledge, and after reset the unit is idle.
- R12: Completion comes one clock after the read acknowledge. There, `done`, `pc_we`, `ccs_we`, `cause_clr` and every selected write enable are high for exactly one cycle, and no write enable is high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request, taken while idle |
| req_cause | input | 2 | Cause code: 0 break, 1 NMI, 2 bus fault, 3 interrupt |
| core_ver | input | 8 | Core version; below 32 selects legacy rules |
| cur_pc | input | 32 | PC at the exception |
| dslot_cnt | input | 2 | Pending delay-slot byte count |
| trap_vec | input | 8 | Vector for break |
| fault_vec | input | 8 | Latched bus-fault vector |
| irq_vec | input | 8 | Vector from the interrupt controller |
| ccs_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ebp_in | input | 32 | Vector table base |
| busy | output | 1 | Entry in progress |
| rd_req | output | 1 | Vector-table read request |
| rd_addr | output | 32 | Vector-table read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| done | output | 1 | Completion pulse |
| pc_we | output | 1 | PC write enable |
| pc_val | output | 32 | New PC (handler address) |
| erp_we | output | 1 | Exception return register write |
| nrp_we | output | 1 | NMI return register write |
| brp_we | output | 1 | Break return register write (legacy) |
| ret_val | output | 32 | Saved return address |
| exs_we | output | 1 | Exception status write |
| exs_val | output | 32 | Exception status value |
| ccs_we | output | 1 | Status word write |
| ccs_val | output | 32 | New status word |
| usp_we | output | 1 | User stack register write |
| usp_val | output | 32 | Value for the user stack register |
| sp_we | output | 1 | Stack pointer write |
| sp_val | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear pending delay slot |
| irq_lock | output | 1 | Interrupt lock pulse (legacy) |
| bus_err | output | 1 | Unhandled legacy bus fault |
| cause_clr | output | 1 | Clear the pending cause |

## Verification
The assertions take for granted that `rd_ack` is raised only while `rd_req` is high, and that the request fields are valid in the cycle where `req_valid` is seen while idle. The bench keeps to these assumptions: it drives the acknowledge only after it sees a read request, and only after a random wait of zero to three cycles. It presents request fields together with `req_valid`, and it changes them freely afterwards, which also shows that the unit latches them. Requests made while busy are injected on purpose, to show that they are ignored.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_BREAK = 2'd0,
    CAUSE_NMI   = 2'd1,
    CAUSE_BUSF  = 2'd2,
    CAUSE_IRQ   = 2'd3
  } exc_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_FIN   = 2'd2,
    ST_FAULT = 2'd3
  } exc_state_e;
endpackage

// File: rtl/exc_route.sv
module exc_route
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8,
  parameter int DS_W  = 2
) (
  input  exc_cause_e       cause,
  input  logic             legacy,
  input  logic [XLEN-1:0]  pc,
  input  logic [DS_W-1:0]  dslot,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [XLEN-1:0]  ebp,
  output logic [XLEN-1:0]  ret_addr,
  output logic             erp_sel,
  output logic             nrp_sel,
  output logic             brp_sel,
  output logic             exs_sel,
  output logic [XLEN-1:0]  exs_word,
  output logic             dslot_clr,
  output logic             set_lock,
  output logic             is_fault,
  output logic [XLEN-1:0]  fetch_addr
);
  localparam int IDX_LSB = 8;
  localparam int IDX_W   = 8;

  logic [VEC_W-1:0] vec;
  logic [XLEN-1:0]  vec_x;

  // Vector and return-register choice per cause and mode
  always_comb begin
    vec     = '0;
    erp_sel = 1'b0;
    nrp_sel = 1'b0;
    brp_sel = 1'b0;
    unique case (cause)
      CAUSE_BREAK: begin
        vec     = trap_vec;
        brp_sel = legacy;
        erp_sel = !legacy;
      end
      CAUSE_NMI: begin
        vec     = '0;
        brp_sel = legacy;
        nrp_sel = !legacy;
      end
      CAUSE_BUSF: begin
        vec     = fault_vec;
        erp_sel = !legacy;
      end
      default: begin
        vec     = irq_vec;
        erp_sel = 1'b1;
      end
    endcase
  end

  always_comb begin
    vec_x      = XLEN'(vec);
    is_fault   = legacy && (cause == CAUSE_BUSF);
    set_lock   = legacy;
    exs_sel    = !legacy;
    exs_word   = XLEN'({vec_x[IDX_W-1:0], {IDX_LSB{1'b0}}});
    dslot_clr  = !legacy && (dslot != '0);
    ret_addr   = legacy ? pc : (pc - XLEN'(dslot));
    fetch_addr = ebp + (vec_x << 2);
  end
endmodule

// File: rtl/exc_ccs_xform.sv
module exc_ccs_xform #(
  parameter int XLEN       = 32,
  parameter int U_BIT      = 8,
  parameter int M_MAIN_BIT = 9,
  parameter int M_OLD_BIT  = 7,
  parameter int F_OLD_BIT  = 6
) (
  input  logic            legacy,
  input  logic            is_nmi,
  input  logic [XLEN-1:0] ccs,
  input  logic [XLEN-1:0] sp,
  input  logic [XLEN-1:0] ksp,
  output logic [XLEN-1:0] ccs_new,
  output logic            swap,
  output logic [XLEN-1:0] usp_new,
  output logic [XLEN-1:0] sp_new
);
  localparam int KEEP_W  = 2;
  localparam int CLEAR_W = 10;
  localparam int MOVE_W  = XLEN - KEEP_W - CLEAR_W;

  logic [XLEN-1:0] masked;

  always_comb begin
    masked = ccs;
    if (is_nmi) begin
      if (legacy) masked[M_OLD_BIT]  = 1'b0;
      else        masked[M_MAIN_BIT] = 1'b0;
    end
    if (legacy) begin
      ccs_new            = masked;
      ccs_new[F_OLD_BIT] = 1'b1;
    end else begin
      ccs_new = {masked[XLEN-1 -: KEEP_W], masked[MOVE_W-1:0], {CLEAR_W{1'b0}}};
    end
    swap    = ccs[U_BIT];
    usp_new = sp;
    sp_new  = ksp;
  end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_fault,
  input  logic rd_ack,
  output logic accept,
  output logic capture,
  output logic busy,
  output logic rd_req,
  output logic fin,
  output logic fault
);
  exc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = req_fault ? ST_FAULT : ST_FETCH;
      ST_FETCH: if (rd_ack)    state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    accept  = (state_q == ST_IDLE) && req_valid;
    rd_req  = (state_q == ST_FETCH);
    capture = rd_req && rd_ack;
    fin     = (state_q == ST_FIN);
    fault   = (state_q == ST_FAULT);
    busy    = (state_q != ST_IDLE);
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 8,
  parameter int DS_W       = 2,
  parameter int VER_W      = 8,
  parameter int LEGACY_VER = 32,
  parameter int U_BIT      = 8,
  parameter int M_MAIN_BIT = 9,
  parameter int M_OLD_BIT  = 7,
  parameter int F_OLD_BIT  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_cause,
  input  logic [VER_W-1:0] core_ver,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [DS_W-1:0]  dslot_cnt,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [XLEN-1:0]  ccs_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  ksp_in,
  input  logic [XLEN-1:0]  ebp_in,
  output logic             busy,
  output logic             rd_req,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rd_ack,
  input  logic [XLEN-1:0]  rd_data,
  output logic             done,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_val,
  output logic             erp_we,
  output logic             nrp_we,
  output logic             brp_we,
  output logic [XLEN-1:0]  ret_val,
  output logic             exs_we,
  output logic [XLEN-1:0]  exs_val,
  output logic             ccs_we,
  output logic [XLEN-1:0]  ccs_val,
  output logic             usp_we,
  output logic [XLEN-1:0]  usp_val,
  output logic             sp_we,
  output logic [XLEN-1:0]  sp_val,
  output logic             dslot_clr,
  output logic             irq_lock,
  output logic             bus_err,
  output logic             cause_clr
);
  exc_cause_e      cause;
  logic            legacy;
  logic [XLEN-1:0] r_ret, r_exs, r_addr;
  logic            r_erp, r_nrp, r_brp, r_exs_en, r_dsc, r_lock, r_fault;
  logic [XLEN-1:0] x_ccs, x_usp, x_sp;
  logic            x_swap;
  logic            accept, capture, fin, fault;

  // Latched entry plan
  logic [XLEN-1:0] q_ret, q_exs, q_addr, q_ccs, q_usp, q_sp, q_pc;
  logic            q_erp, q_nrp, q_brp, q_exs_en, q_dsc, q_lock, q_swap;

  always_comb begin
    cause  = exc_cause_e'(req_cause);
    legacy = (core_ver < VER_W'(LEGACY_VER));
  end

  exc_route #(.XLEN(XLEN), .VEC_W(VEC_W), .DS_W(DS_W)) u_route (
    .cause      (cause),
    .legacy     (legacy),
    .pc         (cur_pc),
    .dslot      (dslot_cnt),
    .trap_vec   (trap_vec),
    .fault_vec  (fault_vec),
    .irq_vec    (irq_vec),
    .ebp        (ebp_in),
    .ret_addr   (r_ret),
    .erp_sel    (r_erp),
    .nrp_sel    (r_nrp),
    .brp_sel    (r_brp),
    .exs_sel    (r_exs_en),
    .exs_word   (r_exs),
    .dslot_clr  (r_dsc),
    .set_lock   (r_lock),
    .is_fault   (r_fault),
    .fetch_addr (r_addr)
  );

  exc_ccs_xform #(
    .XLEN(XLEN), .U_BIT(U_BIT), .M_MAIN_BIT(M_MAIN_BIT),
    .M_OLD_BIT(M_OLD_BIT), .F_OLD_BIT(F_OLD_BIT)
  ) u_ccs (
    .legacy  (legacy),
    .is_nmi  (cause == CAUSE_NMI),
    .ccs     (ccs_in),
    .sp      (sp_in),
    .ksp     (ksp_in),
    .ccs_new (x_ccs),
    .swap    (x_swap),
    .usp_new (x_usp),
    .sp_new  (x_sp)
  );

  exc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_fault (r_fault),
    .rd_ack    (rd_ack),
    .accept    (accept),
    .capture   (capture),
    .busy      (busy),
    .rd_req    (rd_req),
    .fin       (fin),
    .fault     (fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ret    <= '0;
      q_exs    <= '0;
      q_addr   <= '0;
      q_ccs    <= '0;
      q_usp    <= '0;
      q_sp     <= '0;
      q_pc     <= '0;
      q_erp    <= 1'b0;
      q_nrp    <= 1'b0;
      q_brp    <= 1'b0;
      q_exs_en <= 1'b0;
      q_dsc    <= 1'b0;
      q_lock   <= 1'b0;
      q_swap   <= 1'b0;
    end else begin
      if (accept) begin
        q_ret    <= r_ret;
        q_exs    <= r_exs;
        q_addr   <= r_addr;
        q_ccs    <= x_ccs;
        q_usp    <= x_usp;
        q_sp     <= x_sp;
        q_erp    <= r_erp;
        q_nrp    <= r_nrp;
        q_brp    <= r_brp;
        q_exs_en <= r_exs_en;
        q_dsc    <= r_dsc;
        q_lock   <= r_lock;
        q_swap   <= x_swap;
      end
      if (capture) begin
        q_pc <= rd_data;
      end
    end
  end

  always_comb begin
    rd_addr   = q_addr;
    done      = fin;
    cause_clr = fin;
    pc_we     = fin;
    pc_val    = q_pc;
    erp_we    = fin && q_erp;
    nrp_we    = fin && q_nrp;
    brp_we    = fin && q_brp;
    ret_val   = q_ret;
    exs_we    = fin && q_exs_en;
    exs_val   = q_exs;
    ccs_we    = fin;
    ccs_val   = q_ccs;
    usp_we    = fin && q_swap;
    usp_val   = q_usp;
    sp_we     = fin && q_swap;
    sp_val    = q_sp;
    dslot_clr = fin && q_dsc;
    irq_lock  = fin && q_lock;
    bus_err   = fault;
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            rd_req,
  input logic [XLEN-1:0] rd_addr,
  input logic            rd_ack,
  input logic            done,
  input logic            pc_we,
  input logic            erp_we,
  input logic            nrp_we,
  input logic            brp_we,
  input logic            exs_we,
  input logic            ccs_we,
  input logic [XLEN-1:0] ccs_val,
  input logic            usp_we,
  input logic            sp_we,
  input logic            irq_lock,
  input logic            bus_err,
  input logic            cause_clr
);
  AST_RET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erp_we, nrp_we, brp_we})); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R11
  AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R12
  AST_DONE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pc_we && ccs_we && cause_clr); // R12
  AST_WE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we || ccs_we || erp_we || nrp_we || brp_we || exs_we || usp_we || sp_we) |-> done); // R12
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_ack)); // R8
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !done && !rd_req); // R10
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err && !busy); // R10
  AST_SHIFT_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    exs_we |-> (ccs_val[9:0] == 10'd0)); // R7
  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(exs_we && irq_lock)); // R9
  AST_SWAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we == usp_we); // R6
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_ack    (rd_ack),
  .done      (done),
  .pc_we     (pc_we),
  .erp_we    (erp_we),
  .nrp_we    (nrp_we),
  .brp_we    (brp_we),
  .exs_we    (exs_we),
  .ccs_we    (ccs_we),
  .ccs_val   (ccs_val),
  .usp_we    (usp_we),
  .sp_we     (sp_we),
  .irq_lock  (irq_lock),
  .bus_err   (bus_err),
  .cause_clr (cause_clr)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_cause;
  logic [7:0]  core_ver;
  logic [31:0] cur_pc;
  logic [1:0]  dslot_cnt;
  logic [7:0]  trap_vec, fault_vec, irq_vec;
  logic [31:0] ccs_in, sp_in, ksp_in, ebp_in;
  logic        busy, rd_req, rd_ack;
  logic [31:0] rd_addr, rd_data;
  logic        done, pc_we, erp_we, nrp_we, brp_we, exs_we, ccs_we, usp_we, sp_we;
  logic [31:0] pc_val, ret_val, exs_val, ccs_val, usp_val, sp_val;
  logic        dslot_clr, irq_lock, bus_err, cause_clr;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
    .core_ver(core_ver), .cur_pc(cur_pc), .dslot_cnt(dslot_cnt),
    .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
    .ccs_in(ccs_in), .sp_in(sp_in), .ksp_in(ksp_in), .ebp_in(ebp_in),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .done(done), .pc_we(pc_we), .pc_val(pc_val),
    .erp_we(erp_we), .nrp_we(nrp_we), .brp_we(brp_we), .ret_val(ret_val),
    .exs_we(exs_we), .exs_val(exs_val), .ccs_we(ccs_we), .ccs_val(ccs_val),
    .usp_we(usp_we), .usp_val(usp_val), .sp_we(sp_we), .sp_val(sp_val),
    .dslot_clr(dslot_clr), .irq_lock(irq_lock), .bus_err(bus_err),
    .cause_clr(cause_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ccs(input logic [31:0] c, input logic [1:0] cause,
                                         input logic legacy);
    logic [31:0] m = c;
    if (cause == 2'd1) begin
      if (legacy) m[7] = 1'b0;
      else        m[9] = 1'b0;
    end
    if (legacy) begin
      m[6] = 1'b1;
      return m;
    end
    return {m[31:30], m[19:0], 10'd0};
  endfunction

  function automatic logic [7:0] exp_vec(input logic [1:0] cause, input logic [7:0] tv,
                                         input logic [7:0] fv, input logic [7:0] iv);
    case (cause)
      2'd0:    return tv;
      2'd1:    return 8'd0;
      2'd2:    return fv;
      default: return iv;
    endcase
  endfunction

  task automatic scramble();
    req_cause = 2'($urandom);   core_ver  = 8'($urandom);
    cur_pc    = $urandom;       dslot_cnt = 2'($urandom);
    trap_vec  = 8'($urandom);   fault_vec = 8'($urandom);
    irq_vec   = 8'($urandom);   ccs_in    = $urandom;
    sp_in     = $urandom;       ksp_in    = $urandom;
    ebp_in    = $urandom;
  endtask

  task automatic idle_quiet(input string tag);
    chk({tag, " busy"}, {31'd0, busy}, 32'd0);
    chk({tag, " no write"}, {24'd0, pc_we, ccs_we, erp_we, nrp_we, brp_we, exs_we, usp_we, sp_we}, 32'd0);
  endtask

  task automatic run_one(input logic [1:0] cause, input logic legacy, input logic [1:0] ds,
                         input logic user, input logic [31:0] ccs_base, input bit jam);
    logic [31:0] pc, ccs, sp, ksp, ebp, data, addr, ret;
    logic [7:0]  tv, fv, iv, ver, vec;
    int          lat;
    logic        e_erp, e_nrp, e_brp;
    pc = $urandom; sp = $urandom; ksp = $urandom; ebp = $urandom; data = $urandom;
    tv = 8'($urandom); fv = 8'($urandom); iv = 8'($urandom);
    ccs = ccs_base; ccs[8] = user;
    ver = legacy ? 8'($urandom % 32) : 8'(32 + $urandom % 224);
    lat = int'($urandom % 4);
    vec   = exp_vec(cause, tv, fv, iv);
    addr  = ebp + {22'd0, vec, 2'b00};
    ret   = legacy ? pc : pc - {30'd0, ds};
    e_erp = legacy ? (cause == 2'd3) : (cause != 2'd1);
    e_nrp = !legacy && (cause == 2'd1);
    e_brp = legacy && (cause <= 2'd1);

    req_cause = cause; core_ver = ver; cur_pc = pc; dslot_cnt = ds;
    trap_vec = tv; fault_vec = fv; irq_vec = iv; ccs_in = ccs;
    sp_in = sp; ksp_in = ksp; ebp_in = ebp; req_valid = 1'b1; rd_ack = 1'b0;
    @(negedge clk);
    scramble();
    if (legacy && cause == 2'd2) begin
      req_valid = 1'b0;
      chk("R10 bus_err raised", {31'd0, bus_err}, 32'd1);
      chk("R10 no read", {31'd0, rd_req}, 32'd0);
      chk("R10 no done", {31'd0, done}, 32'd0);
      @(negedge clk);
      chk("R10 bus_err one cycle", {31'd0, bus_err}, 32'd0);
      idle_quiet("R10 idle after fault");
      return;
    end
    req_valid = jam;
    chk("R8 read request", {31'd0, rd_req}, 32'd1);
    chk("R8 read address", rd_addr, addr);
    chk("R11 busy after accept", {31'd0, busy}, 32'd1);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R11 read held", {31'd0, rd_req}, 32'd1);
      chk("R11 address stable", rd_addr, addr);
      chk("R12 no early done", {31'd0, done}, 32'd0);
    end
    rd_ack = 1'b1; rd_data = data; req_valid = 1'b0;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = $urandom;
    chk("R12 done", {31'd0, done}, 32'd1);
    chk("R12 pc_we/cause_clr/ccs_we", {29'd0, pc_we, cause_clr, ccs_we}, 32'd7);
    chk("R8 new pc", pc_val, data);
    chk("R1/R2/R3/R9 return select", {29'd0, erp_we, nrp_we, brp_we}, {29'd0, e_erp, e_nrp, e_brp});
    chk("R1/R5/R9 return address", ret_val, ret);
    chk("R4/R9 exs_we", {31'd0, exs_we}, {31'd0, !legacy});
    if (!legacy) chk("R4 exs value", exs_val, {16'd0, vec, 8'd0});
    chk("R2/R7/R9 status word", ccs_val, exp_ccs(ccs, cause, legacy));
    chk("R6 stack swap enables", {30'd0, usp_we, sp_we}, {30'd0, user, user});
    if (user) begin
      chk("R6 usp value", usp_val, sp);
      chk("R6 sp value", sp_val, ksp);
    end
    chk("R5 dslot_clr", {31'd0, dslot_clr}, {31'd0, !legacy && ds != 2'd0});
    chk("R9 irq_lock", {31'd0, irq_lock}, {31'd0, legacy});
    chk("R10 no bus_err", {31'd0, bus_err}, 32'd0);
    @(negedge clk);
    chk("R12 done one cycle", {31'd0, done}, 32'd0);
    idle_quiet("R11/R12 idle after entry");
    chk("R11 busy request ignored", {31'd0, rd_req}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; req_valid = 1'b0; rd_ack = 1'b0; rd_data = '0;
    scramble();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset idle", {29'd0, busy, rd_req, done}, 32'd0);
    chk("R10/R12 reset quiet", {29'd0, bus_err, cause_clr, pc_we}, 32'd0);
    // Every cause in both modes, with and without a delay slot and user mode
    for (int c = 0; c < 4; c++)
      for (int lg = 0; lg < 2; lg++)
        for (int d = 0; d < 2; d++)
          for (int u = 0; u < 2; u++)
            run_one(2'(c), 1'(lg), d ? 2'(1 + $urandom % 3) : 2'd0, 1'(u), $urandom, 1'b0);
    // Corners: all-ones status, maximum delay slot, NMI flag bits set
    run_one(2'd1, 1'b0, 2'd3, 1'b1, 32'hFFFF_FFFF, 1'b1);
    run_one(2'd1, 1'b1, 2'd3, 1'b1, 32'hFFFF_FFFF, 1'b1);
    run_one(2'd0, 1'b0, 2'd3, 1'b0, 32'h0000_0000, 1'b1);
    // Random mix with requests injected while busy
    for (int i = 0; i < 200; i++)
      run_one(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), $urandom, 1'($urandom));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule